// File: doc/BRIEF.md
# Power-Aware Serial Peripheral Shifter

This block is an 8-bit synchronous serial port that can act as bus master, driving the serial clock itself, or as a selected slave that follows an external clock. It runs from one module clock. A small register file holds the setup: enable, role, clock divider, interrupt enable and a control bit that chooses what happens in CPU wait mode. A data register sends a byte on write and returns the last received byte on read. A completion flag, with an optional interrupt, reports each finished byte.

Two system inputs report that the CPU is in wait or in stop mode. A master that is told to save power freezes its clock exactly where it stands and carries on from the same bit afterwards. A slave cannot stop the external clock, so it keeps shifting. Its completion flag and its data register update are held back until the power mode ends. While held back it keeps returning either its programmed byte or an echo of each byte received. The serial format is fixed: the clock idles low, data is sampled on the rising edge and changed on the falling edge, most significant bit first.

Top module: `spi_pm_core`

## Requirements
- R1: After reset, the control register and the status register read 0, and irq, sck_out and miso_oe are low. A read returns its value on reg_rdata one clock after the read strobe.
- R2: Address 0 is control: bit 0 enable, bit 1 master role, bit 2 stop-in-wait, bit 3 interrupt enable, bits 6:4 divider select, bit 7 reads 0. Address 1 is status, with the completion flag at bit 7. Address 2 is data: a write sets the byte to send and a read returns the last received byte.
- R3: A master transfer starts when the data register is written while the block is enabled and idle. It shifts 8 bits most significant first, changes mosi_out on falling sck_out edges and samples miso_in on rising edges. It then stores the received byte and sets the flag.
- R4: With divider select n, each high phase and each low phase of sck_out lasts 2^n module clocks.
- R5: The flag is cleared only by a status read made while the flag is set, followed by a read or write of the data register. A data access with no such status read first leaves the flag set.
- R6: irq goes high one clock after the flag is set while interrupts are enabled, and goes low after the flag clears.
- R7: While enable is 0, the registers can still be written and read back, sck_out stays low, and a data write starts no transfer.
- R8: In wait mode with stop-in-wait clear, the block works exactly as in run mode.
- R9: A master in stop mode, or in wait mode with stop-in-wait set, holds sck_out and its bit position frozen. When the mode ends it resumes from that bit and delivers correct data in both directions.
- R10: A slave with ss_n_in low shifts in mode 0 from sck_in and mosi_in, drives miso_out from the last data-register write, and stores each received byte and sets the flag.
- R11: A slave with ss_n_in high drives miso_oe low, and sck_in toggles have no effect on its bit position.
- R12: A slave in a power-saving mode keeps shifting, but sets no flag and leaves the data register unchanged until the mode ends.
- R13: During a power-saving mode, a slave that was sending a written byte sends that same byte again on every following byte. Otherwise it echoes each byte received, one byte later.
- R14: When the mode ends, the last byte received during the mode is copied into the data register and the flag is set. This happens if a byte was in progress at entry or at exit. If the slave was idle at both, there is no copy and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| cpu_wait | input | 1 | CPU is in wait mode |
| cpu_stop | input | 1 | CPU is in stop mode |
| irq | output | 1 | Transfer-complete interrupt |
| sck_out | output | 1 | Serial clock driven as master |
| mosi_out | output | 1 | Serial data out as master |
| mst_oe | output | 1 | Master pins driven (enabled and master) |
| miso_in | input | 1 | Serial data in as master |
| sck_in | input | 1 | Serial clock in as slave |
| mosi_in | input | 1 | Serial data in as slave |
| ss_n_in | input | 1 | Slave select, active low |
| miso_out | output | 1 | Serial data out as slave |
| miso_oe | output | 1 | Slave output enable |

## Verification
The assertions take for granted that slave-side inputs change slowly next to the module clock, with each sck_in level held for at least four clocks, so that the synchronizers catch every edge. They also assume that cpu_wait and cpu_stop never change in the same clock that a slave byte completes, and that the role and enable bits change only while no byte is in flight. The stimulus holds every external clock level for eight module clocks. It changes power inputs several clocks away from any serial edge and rewrites control only between transfers. Random bytes and divider settings are drawn inside those limits.

// File: rtl/spi_pm_pkg.sv
package spi_pm_pkg;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;
  localparam int B_EN   = 0;
  localparam int B_MST  = 1;
  localparam int B_SIW  = 2;
  localparam int B_IE   = 3;
  localparam int B_BAUD = 4;
endpackage

// File: rtl/spi_pm_sync.sv
module spi_pm_sync #(
  parameter int N = 3,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/spi_pm_baud.sv
module spi_pm_baud #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int CW = (1 << SEL_W) - 1;
  localparam logic [CW:0] ONE = 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim  = CW'((ONE << sel) - ONE);
  assign tick = run && (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  // R4: the divider never runs past its terminal count
  a_r4_div_in_range: assert property (@(posedge clk) disable iff (rst)
    run && !tick |=> !run || (cnt <= lim) || $changed(sel));
endmodule

// File: rtl/spi_pm_engine.sv
module spi_pm_engine #(
  parameter int W = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             master,
  input  logic             lp,
  input  logic [SEL_W-1:0] baud_sel,
  input  logic             load,
  input  logic [W-1:0]     load_data,
  input  logic [W-1:0]     tx_buf,
  input  logic             miso_in,
  input  logic             sck_s,
  input  logic             mosi_s,
  input  logic             ss_s,
  output logic             sck_out,
  output logic             mosi_out,
  output logic             miso_out,
  output logic             miso_oe,
  output logic             idle,
  output logic             done,
  output logic [W-1:0]     done_data
);
  localparam int CNT_W = $clog2(W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  logic [W-1:0]     sh, pend, done_d;
  logic [CNT_W-1:0] cnt;
  logic samp, m_busy, sck_q, sck_d, lp_q, ent_busy, pend_v, src_dr, oe_q, done_q;
  logic tick;

  wire m_run   = en && master && m_busy && !lp;
  wire m_frz   = en && master && lp;
  wire s_act   = en && !master && !ss_s;
  wire s_rise  = s_act && sck_s && !sck_d;
  wire s_fall  = s_act && !sck_s && sck_d;
  wire at_last = (cnt == LAST);
  wire lp_in   = lp && !lp_q;
  wire lp_out  = !lp && lp_q;
  wire [W-1:0] shifted = {sh[W-2:0], samp};

  spi_pm_baud #(.SEL_W(SEL_W)) u_baud (
    .clk(clk), .rst(rst), .run(m_run), .sel(baud_sel), .tick(tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sh <= '0; pend <= '0; done_d <= '0; cnt <= '0;
      samp <= 1'b0; m_busy <= 1'b0; sck_q <= 1'b0; sck_d <= 1'b0;
      lp_q <= 1'b0; ent_busy <= 1'b0; pend_v <= 1'b0; src_dr <= 1'b0;
      oe_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      sck_d  <= sck_s;
      lp_q   <= lp;
      oe_q   <= s_act;
      if (!en) begin
        cnt <= '0; m_busy <= 1'b0; sck_q <= 1'b0; pend_v <= 1'b0;
      end else if (master) begin
        if (load && !m_busy) begin
          sh <= load_data; m_busy <= 1'b1; cnt <= '0;
        end else if (tick) begin
          if (!sck_q) begin
            sck_q <= 1'b1; samp <= miso_in;
          end else begin
            sck_q <= 1'b0; sh <= shifted;
            if (at_last) begin
              cnt <= '0; m_busy <= 1'b0; done_q <= 1'b1; done_d <= shifted;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
      end else begin
        m_busy <= 1'b0;
        sck_q  <= 1'b0;
        if (lp_in) ent_busy <= (cnt != '0);
        if (lp_out) begin
          if (pend_v && (ent_busy || cnt != '0)) begin
            done_q <= 1'b1; done_d <= pend;
          end
          pend_v <= 1'b0;
        end
        if (ss_s) begin
          cnt <= '0;
        end else if (s_rise) begin
          samp <= mosi_s;
        end else if (s_fall) begin
          if (at_last) begin
            cnt <= '0;
            if (lp) begin
              pend <= shifted; pend_v <= 1'b1;
              sh <= src_dr ? tx_buf : shifted;
            end else begin
              done_q <= 1'b1; done_d <= shifted; sh <= shifted; src_dr <= 1'b0;
            end
          end else begin
            sh <= shifted; cnt <= cnt + 1'b1;
          end
        end
        if (load) begin
          sh <= load_data; src_dr <= 1'b1;
        end
      end
    end
  end

  assign sck_out   = sck_q;
  assign mosi_out  = sh[W-1];
  assign miso_out  = sh[W-1];
  assign miso_oe   = oe_q;
  assign idle      = (cnt == '0) && !m_busy;
  assign done      = done_q;
  assign done_data = done_d;

  // R9: a frozen master keeps its clock level and bit position
  a_r9_master_frozen: assert property (@(posedge clk) disable iff (rst)
    m_frz |=> $stable(sck_q) && $stable(cnt));
  // R7: a disabled block holds no bit position and no clock
  a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    !en |=> (cnt == '0) && !sck_q);
  // R11: deselected slave releases its output
  a_r11_deselect_release: assert property (@(posedge clk) disable iff (rst)
    ss_s && !master |=> !oe_q);
  // R12: no completion reported by a slave while power saving holds
  a_r12_no_done_in_lp: assert property (@(posedge clk) disable iff (rst)
    en && !master && lp && lp_q |=> !done_q);
endmodule

// File: rtl/spi_pm_core.sv
module spi_pm_core
  import spi_pm_pkg::*;
#(
  parameter int W = 8,
  parameter int SEL_W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         reg_wr,
  input  logic         reg_rd,
  input  logic [1:0]   reg_addr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  input  logic         cpu_wait,
  input  logic         cpu_stop,
  output logic         irq,
  output logic         sck_out,
  output logic         mosi_out,
  output logic         mst_oe,
  input  logic         miso_in,
  input  logic         sck_in,
  input  logic         mosi_in,
  input  logic         ss_n_in,
  output logic         miso_out,
  output logic         miso_oe
);
  logic c_en, c_mst, c_siw, c_ie;
  logic [SEL_W-1:0] c_baud;
  logic [W-1:0] tx_buf, rx_buf, rd_mux;
  logic flag, arm;
  logic sck_s, mosi_s, ss_s;
  logic eng_idle, eng_done;
  logic [W-1:0] eng_data;

  wire lp       = cpu_stop || (cpu_wait && c_siw);
  wire data_acc = (reg_wr || reg_rd) && (reg_addr == A_DATA);
  wire load     = reg_wr && (reg_addr == A_DATA) && c_en && eng_idle;

  spi_pm_sync #(.N(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst),
    .d({ss_n_in, mosi_in, sck_in}),
    .q({ss_s, mosi_s, sck_s})
  );

  spi_pm_engine #(.W(W), .SEL_W(SEL_W)) u_eng (
    .clk(clk), .rst(rst), .en(c_en), .master(c_mst), .lp(lp),
    .baud_sel(c_baud), .load(load), .load_data(reg_wdata), .tx_buf(tx_buf),
    .miso_in(miso_in), .sck_s(sck_s), .mosi_s(mosi_s), .ss_s(ss_s),
    .sck_out(sck_out), .mosi_out(mosi_out), .miso_out(miso_out),
    .miso_oe(miso_oe), .idle(eng_idle), .done(eng_done), .done_data(eng_data)
  );

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      A_CTRL: begin
        rd_mux[B_EN]  = c_en;
        rd_mux[B_MST] = c_mst;
        rd_mux[B_SIW] = c_siw;
        rd_mux[B_IE]  = c_ie;
        rd_mux[B_BAUD +: SEL_W] = c_baud;
      end
      A_STAT:  rd_mux[W-1] = flag;
      A_DATA:  rd_mux = rx_buf;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      c_en <= 1'b0; c_mst <= 1'b0; c_siw <= 1'b0; c_ie <= 1'b0; c_baud <= '0;
      tx_buf <= '0; rx_buf <= '0; flag <= 1'b0; arm <= 1'b0;
      irq <= 1'b0; reg_rdata <= '0;
    end else begin
      irq <= flag && c_ie;
      if (reg_wr && reg_addr == A_CTRL) begin
        c_en   <= reg_wdata[B_EN];
        c_mst  <= reg_wdata[B_MST];
        c_siw  <= reg_wdata[B_SIW];
        c_ie   <= reg_wdata[B_IE];
        c_baud <= reg_wdata[B_BAUD +: SEL_W];
      end
      if (reg_wr && reg_addr == A_DATA) tx_buf <= reg_wdata;
      if (reg_rd) reg_rdata <= rd_mux;
      if (eng_done) begin
        flag <= 1'b1; rx_buf <= eng_data; arm <= 1'b0;
      end else if (flag && arm && data_acc) begin
        flag <= 1'b0; arm <= 1'b0;
      end else if (flag && reg_rd && reg_addr == A_STAT) begin
        arm <= 1'b1;
      end
    end
  end

  assign mst_oe = c_en && c_mst;

  // R6: interrupt never without a pending flag
  a_r6_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
    !flag |=> !irq);
  // R3: the flag only rises on a completed byte from the engine
  a_r3_flag_from_done: assert property (@(posedge clk) disable iff (rst)
    !flag && !eng_done |=> !flag);
  // R5: the flag drops only after an armed data access
  a_r5_clear_needs_arm: assert property (@(posedge clk) disable iff (rst)
    flag && !(arm && data_acc) |=> flag);
endmodule

// File: tb/spi_pm_core_test.sv
`timescale 1ns/1ps
module spi_pm_core_test;
  logic clk = 1'b0, rst = 1'b1;
  logic reg_wr = 0, reg_rd = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic cpu_wait = 0, cpu_stop = 0;
  logic irq, sck_out, mosi_out, mst_oe, miso_in, miso_out, miso_oe;
  logic sck_in = 0, mosi_in = 0, ss_n_in = 1;

  int checks = 0, fails = 0, cyc = 0;
  int hicnt = 0, rises = 0;
  logic [7:0] bslv = 0, bcap = 0;

  spi_pm_core uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_wait(cpu_wait),
    .cpu_stop(cpu_stop), .irq(irq), .sck_out(sck_out), .mosi_out(mosi_out),
    .mst_oe(mst_oe), .miso_in(miso_in), .sck_in(sck_in), .mosi_in(mosi_in),
    .ss_n_in(ss_n_in), .miso_out(miso_out), .miso_oe(miso_oe)
  );

  always #2.5 clk = ~clk;

  assign miso_in = bslv[7];
  always @(negedge sck_out) bslv = {bslv[6:0], 1'b0};
  always @(posedge sck_out) begin bcap = {bcap[6:0], mosi_out}; rises++; end
  always @(negedge clk) if (sck_out) hicnt++;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog all actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  function automatic [7:0] ctrl_val(input bit en, mst, siw, ie, input [2:0] bd);
    return {1'b0, bd, ie, siw, mst, en};
  endfunction

  task automatic chk(input string tag, input [31:0] act, input [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wreg(input [1:0] a, input [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rreg(input [1:0] a, output [7:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic clear_flag();
    logic [7:0] t;
    rreg(2'd1, t); rreg(2'd2, t);
  endtask

  // one slave byte driven from the bench; raise cpu_stop after bit index stop_at
  task automatic sbyte(input [7:0] mo, output [7:0] mi, input int stop_at);
    for (int b = 7; b >= 0; b--) begin
      mosi_in = mo[b]; idle(8);
      sck_in = 1; idle(4); mi[b] = miso_out; idle(4);
      sck_in = 0;
      if (b == stop_at) begin idle(6); cpu_stop = 1; end
    end
    idle(8);
  endtask

  task automatic mstart(input [7:0] tx, input [7:0] sl);
    bslv = sl; bcap = 0; hicnt = 0; rises = 0;
    wreg(2'd2, tx);
  endtask

  initial begin
    logic [7:0] v, cap;
    logic [7:0] x, y1, y2, c, d, e;
    void'($urandom(32'h5eed_1234));
    idle(4); rst = 0; idle(2);

    // R1 reset state
    rreg(2'd0, v); chk("R1 ctrl after reset", v, 8'h00);
    rreg(2'd1, v); chk("R1 status after reset", v, 8'h00);
    chk("R1 idle pins", {irq, sck_out, miso_oe}, 3'b000);

    // R2 R7 register access while disabled; no transfer
    wreg(2'd0, 8'h7E); rreg(2'd0, v); chk("R2 R7 ctrl readback", v, ctrl_val(0,1,1,1,3'd7));
    rises = 0; wreg(2'd2, 8'hA5); idle(300);
    chk("R7 no clock while disabled", rises, 0);
    rreg(2'd1, v); chk("R7 no flag while disabled", v, 8'h00);

    // R3 R4 random master transfers
    for (int k = 0; k < 6; k++) begin
      logic [2:0] sel; logic [7:0] tx, sl;
      sel = 3'($urandom_range(0, 3)); tx = 8'($urandom); sl = 8'($urandom);
      wreg(2'd0, ctrl_val(1,1,0,0,sel));
      mstart(tx, sl); idle(16 * (1 << sel) + 20);
      chk("R3 master mosi bits", bcap, tx);
      chk("R4 sck high cycles", hicnt, 8 * (1 << sel));
      rreg(2'd1, v); chk("R3 flag set", v, 8'h80);
      rreg(2'd2, v); chk("R3 rx data", v, sl);
      rreg(2'd1, v); chk("R5 flag cleared", v, 8'h00);
    end

    // R5 data access without prior status read keeps flag; R6 irq
    wreg(2'd0, ctrl_val(1,1,0,1,3'd0));
    mstart(8'h3C, 8'hC3); idle(40);
    chk("R6 irq raised", irq, 1'b1);
    rreg(2'd2, v); rreg(2'd1, v); chk("R5 flag kept without arm", v, 8'h80);
    rreg(2'd2, v); chk("R5 rx value", v, 8'hC3);
    idle(2); chk("R6 irq dropped", irq, 1'b0);

    // R8 wait with stop-in-wait clear runs normally
    wreg(2'd0, ctrl_val(1,1,0,0,3'd1));
    cpu_wait = 1; mstart(8'h5A, 8'h96); idle(60);
    chk("R8 runs in wait", rises, 8);
    rreg(2'd2, v); chk("R8 rx in wait", v, 8'h96);
    cpu_wait = 0; clear_flag();

    // R9 master frozen in wait (stop-in-wait set) then in stop (bit clear)
    wreg(2'd0, ctrl_val(1,1,1,0,3'd2));
    mstart(8'hE1, 8'h1E); idle(30);
    cpu_wait = 1; idle(3); v = {7'd0, sck_out}; cap = 8'(rises); idle(150);
    chk("R9 wait freeze edges", rises, cap);
    chk("R9 wait freeze level", sck_out, v[0]);
    cpu_wait = 0; idle(200);
    chk("R9 resumed edges", rises, 8);
    chk("R9 mosi after wait", bcap, 8'hE1);
    rreg(2'd1, v); rreg(2'd2, v); chk("R9 rx after wait", v, 8'h1E);
    wreg(2'd0, ctrl_val(1,1,0,0,3'd2));
    mstart(8'h47, 8'hB8); idle(50);
    cpu_stop = 1; idle(3); cap = 8'(rises); idle(150);
    chk("R9 stop freeze edges", rises, cap);
    cpu_stop = 0; idle(200);
    rreg(2'd1, v); rreg(2'd2, v); chk("R9 rx after stop", v, 8'hB8);
    chk("R9 mosi after stop", bcap, 8'h47);

    // R10 R11 slave basics
    wreg(2'd0, ctrl_val(1,0,0,0,3'd0));
    idle(4); chk("R11 deselected oe", miso_oe, 1'b0);
    for (int t = 0; t < 5; t++) begin sck_in = 1; idle(8); sck_in = 0; idle(8); end
    rreg(2'd1, v); chk("R11 no flag when deselected", v, 8'h00);
    ss_n_in = 0; idle(6); chk("R10 selected oe", miso_oe, 1'b1);
    wreg(2'd2, 8'h6B);
    sbyte(8'h92, cap, -1);
    chk("R10 R11 slave miso", cap, 8'h6B);
    rreg(2'd1, v); rreg(2'd2, v); chk("R10 slave rx", v, 8'h92);

    // R12 R13 R14 repeat of written byte in stop
    x = 8'($urandom); y1 = 8'($urandom); y2 = 8'($urandom);
    wreg(2'd2, x);
    sbyte(y1, cap, 4); chk("R13 first byte", cap, x);
    sbyte(y2, cap, -1); chk("R13 repeat byte", cap, x);
    rreg(2'd1, v); chk("R12 no flag in stop", v, 8'h00);
    rreg(2'd2, v); chk("R12 rx held in stop", v, 8'h92);
    cpu_stop = 0; idle(3);
    rreg(2'd1, v); chk("R14 flag on exit", v, 8'h80);
    rreg(2'd2, v); chk("R14 copy on exit", v, y2);

    // R13 echo path
    c = 8'($urandom); d = 8'($urandom); e = 8'($urandom);
    sbyte(c, cap, -1); chk("R13 reload after exit", cap, x);
    clear_flag();
    sbyte(d, cap, 4); chk("R13 echo first", cap, c);
    sbyte(e, cap, -1); chk("R13 echo previous", cap, d);
    cpu_stop = 0; idle(3);
    rreg(2'd1, v); rreg(2'd2, v); chk("R14 echo copy", v, e);

    // R14 idle at entry and exit: nothing
    cpu_stop = 1; idle(4);
    sbyte(8'h0F, cap, -1);
    cpu_stop = 0; idle(3);
    rreg(2'd1, v); chk("R14 no flag idle-idle", v, 8'h00);
    rreg(2'd2, v); chk("R14 no copy idle-idle", v, e);

    ss_n_in = 1; idle(10);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule